// File: doc/BRIEF.md
# Analog input scan sequencer

This block paces a multiplexed analog-input acquisition. A host fills a channel list through a write port. Each stored entry names an input channel, a gain/polarity range, single-ended or differential wiring, and whether it closes a scan. The host also loads three timing values: a delay before the first scan, a period between scan starts, and a gap between conversions inside a scan. A further value sets the wait from the start of a scan to its first conversion. A read strobe on the start address begins the run. The sequencer then walks the list and issues one convert strobe per entry. With each strobe it presents that entry's channel, range and wiring to the converter.

Four trigger modes decide which events come from the internal timers and which come from an external trigger line. In the fully timed mode, scans and conversions are both paced internally. In the other modes an external rising edge starts the run, starts each scan, or fires each conversion. At the end of a scan the sequencer returns to the first entry. A stop command lets the current scan finish. An immediate stop halts the run at once. The converter, the analog front end and the bus bridge are outside this block. The converter is seen only through the strobe and the entry fields.

Top module: `ai_scan_seq`

## Requirements
- R1: Host writes are taken at the clock edge that samples `wr_en`. Address 0 is control: bits 2:0 mode (bit 2 ignored), bit 3 stop at end of scan, bit 4 immediate stop, bit 5 list enable. Address 1 appends a list entry. Address 2 holds the conversion gap and address 3 the first-conversion wait. Addresses 4/5 hold the scan period (low/high word) and addresses 6/7 the start delay (low/high word). Every timer is loaded with its tick count minus one, so a loaded value L spans L+1 clock cycles.
- R2: A list entry carries the channel in bits 4:0, the differential flag in bit 5, the range code in bits 7:6 and the last-entry marker in bit 8. The range code is stored inverted. With each strobe, `cvt_range` presents the bitwise inverse of the stored code, `cvt_chan` the channel, `cvt_diff` the flag, and `cvt_last` whether the entry closes the scan.
- R3: After reset `busy` and `cvt_stb` are low and the list is empty.
- R4: In mode 0, a start read sampled at edge s with start delay D and first-conversion wait P produces the first strobe at edge s+D+P+2. Each later entry of the scan strobes C+1 edges after the previous one, where C is the conversion gap.
- R5: A scan ends after the entry marked last, or after the final stored entry if none is marked. The next scan then begins at entry 0. Entries stored after a marked entry are never converted. With a scan period of 0 the next scan begins at once, and its first strobe comes P+1 edges after the previous strobe.
- R6: In modes 0 and 1, a nonzero scan period S makes consecutive scans start S+1 cycles apart, so their first strobes are S+1 edges apart.
- R7: In mode 1 the start read only arms the sequencer. No strobe is issued until a rising edge of `ext_trig`, sampled at edge t. The first strobe then comes at edge t+D+P+2.
- R8: In mode 2 the start behaves as in mode 1. Every later scan waits for a rising edge of `ext_trig` at edge t, and its first strobe comes at edge t+P+1. Without a trigger, no strobe follows the end of a scan.
- R9: In mode 3, each rising edge of `ext_trig` sampled at edge t strobes the next entry at edge t, once the start delay has run out. Rising edges during the start delay are ignored.
- R10: A control write with bit 4 set halts the run at its write edge. `busy` is low in the next cycle and no further strobe appears.
- R11: A control write with bit 3 set during a run lets the current scan finish its remaining entries. The sequencer then goes idle without starting another scan.
- R12: `busy` is high from an accepted start until the run ends. List writes made while `busy` is high are ignored.
- R13: A control write with bit 5 clear empties the list and halts any run. A start read with an empty list is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the timers count its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host register write strobe |
| wr_addr | input | 3 | Host register address |
| wr_data | input | TMR_W | Host write data |
| start_rd | input | 1 | Read strobe on the start address; begins a run |
| ext_trig | input | 1 | External trigger line; rising edges are used |
| busy | output | 1 | Sequencer is running or armed |
| cvt_stb | output | 1 | One-cycle convert strobe |
| cvt_chan | output | CH_W | Channel of the strobed entry |
| cvt_range | output | 2 | Range index of the strobed entry (stored code inverted) |
| cvt_diff | output | 1 | Differential flag of the strobed entry |
| cvt_last | output | 1 | The strobed entry closes its scan |

## Verification
The hardest case to reach from the ports is a run that is disturbed part-way through a scan. This covers a stop request that lands between two conversions of one scan, and a list write made while the sequencer is running. The stimulus counts clock edges from the sampled start read and places the stop write exactly one edge after the first strobe, so two entries of the scan remain. For the list write, the entries have no last marker, so an accepted write would show up as an extra channel before the wrap. Mode 3 also needs a trigger pulse placed inside the start delay, which is made by pulsing the line twice in quick succession right after arming.

// File: rtl/ai_scan_pkg.sv
package ai_scan_pkg;

    // host register addresses
    localparam logic [2:0] A_CTRL    = 3'd0;
    localparam logic [2:0] A_LIST    = 3'd1;
    localparam logic [2:0] A_CONV    = 3'd2;
    localparam logic [2:0] A_PRE     = 3'd3;
    localparam logic [2:0] A_SCAN_LO = 3'd4;
    localparam logic [2:0] A_SCAN_HI = 3'd5;
    localparam logic [2:0] A_DLY_LO  = 3'd6;
    localparam logic [2:0] A_DLY_HI  = 3'd7;

    // control bits
    localparam int CB_STOP   = 3;
    localparam int CB_ISTOP  = 4;
    localparam int CB_LISTEN = 5;

    // list entry fields
    localparam int EB_DIFF  = 5;
    localparam int EB_RNG   = 6;
    localparam int EB_LAST  = 8;
    localparam int ENTRY_W  = 9;

    typedef enum logic [1:0] {
        MD_TIMED     = 2'd0,
        MD_EXT_START = 2'd1,
        MD_EXT_SCAN  = 2'd2,
        MD_EXT_CONV  = 2'd3
    } md_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_ARM,
        SQ_DELAY,
        SQ_PRE,
        SQ_CONV,
        SQ_SWAIT,
        SQ_XCONV
    } sq_state_e;

endpackage

// File: rtl/ai_scan_regs.sv
module ai_scan_regs
    import ai_scan_pkg::*;
#(
    parameter int TMR_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [2:0]           wr_addr,
    input  logic [TMR_W-1:0]     wr_data,
    input  logic                 busy,
    output md_e                  mode,
    output logic                 stop_cmd,
    output logic                 istop_cmd,
    output logic                 list_clr,
    output logic                 list_wr,
    output logic [ENTRY_W-1:0]   list_wdata,
    output logic [TMR_W-1:0]     conv_ld,
    output logic [TMR_W-1:0]     pre_ld,
    output logic [2*TMR_W-1:0]   scan_ld,
    output logic [2*TMR_W-1:0]   dly_ld
);

    typedef struct packed {
        logic [1:0]       mode;
        logic             list_en;
        logic [TMR_W-1:0] conv;
        logic [TMR_W-1:0] pre;
        logic [TMR_W-1:0] scan_lo;
        logic [TMR_W-1:0] scan_hi;
        logic [TMR_W-1:0] dly_lo;
        logic [TMR_W-1:0] dly_hi;
    } regs_t;

    regs_t q, d;
    logic  wr_ctrl;

    always_comb begin
        d       = q;
        wr_ctrl = wr_en && (wr_addr == A_CTRL);
        if (wr_en) begin
            case (wr_addr)
                A_CTRL: begin
                    d.mode    = wr_data[1:0];
                    d.list_en = wr_data[CB_LISTEN];
                end
                A_CONV:    d.conv    = wr_data;
                A_PRE:     d.pre     = wr_data;
                A_SCAN_LO: d.scan_lo = wr_data;
                A_SCAN_HI: d.scan_hi = wr_data;
                A_DLY_LO:  d.dly_lo  = wr_data;
                A_DLY_HI:  d.dly_hi  = wr_data;
                default: ;
            endcase
        end
        stop_cmd   = wr_ctrl && wr_data[CB_STOP];
        list_clr   = wr_ctrl && !wr_data[CB_LISTEN];
        istop_cmd  = wr_ctrl && (wr_data[CB_ISTOP] || !wr_data[CB_LISTEN]);
        list_wr    = wr_en && (wr_addr == A_LIST) && q.list_en && !busy;
        list_wdata = wr_data[ENTRY_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mode    = md_e'(q.mode);
    assign conv_ld = q.conv;
    assign pre_ld  = q.pre;
    assign scan_ld = {q.scan_hi, q.scan_lo};
    assign dly_ld  = {q.dly_hi, q.dly_lo};

endmodule

// File: rtl/ai_scan_list.sv
module ai_scan_list
    import ai_scan_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               wr,
    input  logic [ENTRY_W-1:0] wdata,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [ENTRY_W-1:0] rdata,
    output logic [IDX_W:0]     count
);

    logic [ENTRY_W-1:0] mem [DEPTH];
    logic [IDX_W:0]     cnt_q, cnt_d;
    logic               accept;

    always_comb begin
        accept = wr && (cnt_q != IDX_W'(0) + (IDX_W+1)'(DEPTH));
        cnt_d  = cnt_q;
        if (clr)         cnt_d = '0;
        else if (accept) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    always_ff @(posedge clk) begin
        if (accept && !clr) mem[cnt_q[IDX_W-1:0]] <= wdata;
    end

    assign rdata = mem[rd_idx];
    assign count = cnt_q;

endmodule

// File: rtl/ai_scan_fsm.sv
module ai_scan_fsm
    import ai_scan_pkg::*;
#(
    parameter int TMR_W = 32,
    parameter int CH_W  = 5,
    parameter int IDX_W = 10,
    localparam int LW   = 2 * TMR_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_rd,
    input  logic               ext_trig,
    input  md_e                mode,
    input  logic               stop_cmd,
    input  logic               istop_cmd,
    input  logic [TMR_W-1:0]   conv_ld,
    input  logic [TMR_W-1:0]   pre_ld,
    input  logic [LW-1:0]      scan_ld,
    input  logic [LW-1:0]      dly_ld,
    input  logic [IDX_W:0]     list_cnt,
    input  logic [ENTRY_W-1:0] entry,
    output logic [IDX_W-1:0]   rd_idx,
    output logic               busy,
    output logic               cvt_stb,
    output logic [CH_W-1:0]    cvt_chan,
    output logic [1:0]         cvt_range,
    output logic               cvt_diff,
    output logic               cvt_last
);

    typedef struct packed {
        sq_state_e        state;
        logic [LW-1:0]    cnt;
        logic [LW-1:0]    scan_cnt;
        logic [IDX_W-1:0] idx;
        logic             stop_req;
        logic             trig;
        logic             stb;
        logic [CH_W-1:0]  chan;
        logic [1:0]       rng;
        logic             diff;
        logic             last;
    } sq_t;

    sq_t  q, d;
    logic rise;
    logic entry_last;
    logic do_fire;
    logic do_begin;
    logic stop_now;

    always_comb begin
        d          = q;
        d.trig     = ext_trig;
        d.stb      = 1'b0;
        d.scan_cnt = (q.scan_cnt != '0) ? q.scan_cnt - 1'b1 : '0;
        rise       = ext_trig && !q.trig;
        entry_last = entry[EB_LAST] || ({1'b0, q.idx} == list_cnt - 1'b1);
        stop_now   = q.stop_req || stop_cmd;
        do_fire    = 1'b0;
        do_begin   = 1'b0;

        case (q.state)
            SQ_IDLE: begin
                if (start_rd && list_cnt != '0) begin
                    d.idx      = '0;
                    d.stop_req = 1'b0;
                    if (mode == MD_TIMED) begin
                        d.state = SQ_DELAY;
                        d.cnt   = dly_ld;
                    end else begin
                        d.state = SQ_ARM;
                    end
                end
            end
            SQ_ARM: begin
                if (rise) begin
                    d.state = SQ_DELAY;
                    d.cnt   = dly_ld;
                end
            end
            SQ_DELAY: begin
                if (q.cnt == '0) begin
                    if (mode == MD_EXT_CONV) d.state = SQ_XCONV;
                    else                     do_begin = 1'b1;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            SQ_PRE, SQ_CONV: begin
                if (q.cnt == '0) do_fire = 1'b1;
                else             d.cnt   = q.cnt - 1'b1;
            end
            SQ_SWAIT: begin
                if (mode == MD_EXT_SCAN) do_begin = rise;
                else                     do_begin = (q.scan_cnt == '0);
            end
            SQ_XCONV: begin
                do_fire = rise;
            end
            default: d.state = SQ_IDLE;
        endcase

        if (q.state != SQ_IDLE && stop_cmd) d.stop_req = 1'b1;

        if (do_fire) begin
            d.stb  = 1'b1;
            d.chan = entry[CH_W-1:0];
            d.rng  = ~entry[EB_RNG+1:EB_RNG];
            d.diff = entry[EB_DIFF];
            d.last = entry_last;
            if (entry_last) begin
                d.idx = '0;
                if (stop_now) begin
                    d.state = SQ_IDLE;
                end else if (q.state != SQ_XCONV) begin
                    if (mode == MD_EXT_SCAN || scan_ld != '0) d.state = SQ_SWAIT;
                    else                                      do_begin = 1'b1;
                end
            end else begin
                d.idx = q.idx + 1'b1;
                if (q.state != SQ_XCONV) begin
                    d.state = SQ_CONV;
                    d.cnt   = {{TMR_W{1'b0}}, conv_ld};
                end
            end
        end

        if (do_begin) begin
            d.state    = SQ_PRE;
            d.cnt      = {{TMR_W{1'b0}}, pre_ld};
            d.scan_cnt = scan_ld;
        end

        if (istop_cmd) begin
            d.state    = SQ_IDLE;
            d.stb      = 1'b0;
            d.stop_req = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rd_idx    = q.idx;
    assign busy      = (q.state != SQ_IDLE);
    assign cvt_stb   = q.stb;
    assign cvt_chan  = q.chan;
    assign cvt_range = q.rng;
    assign cvt_diff  = q.diff;
    assign cvt_last  = q.last;

endmodule

// File: rtl/ai_scan_seq.sv
module ai_scan_seq
    import ai_scan_pkg::*;
#(
    parameter int TMR_W      = 32,
    parameter int CH_W       = 5,
    parameter int LIST_DEPTH = 1024,
    localparam int IDX_W     = $clog2(LIST_DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [TMR_W-1:0] wr_data,
    input  logic             start_rd,
    input  logic             ext_trig,
    output logic             busy,
    output logic             cvt_stb,
    output logic [CH_W-1:0]  cvt_chan,
    output logic [1:0]       cvt_range,
    output logic             cvt_diff,
    output logic             cvt_last
);

    md_e                mode;
    logic               stop_cmd;
    logic               istop_cmd;
    logic               list_clr;
    logic               list_wr;
    logic [ENTRY_W-1:0] list_wdata;
    logic [TMR_W-1:0]   conv_ld;
    logic [TMR_W-1:0]   pre_ld;
    logic [2*TMR_W-1:0] scan_ld;
    logic [2*TMR_W-1:0] dly_ld;
    logic [IDX_W-1:0]   rd_idx;
    logic [ENTRY_W-1:0] entry;
    logic [IDX_W:0]     list_cnt;

    ai_scan_regs #(.TMR_W(TMR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .busy       (busy),
        .mode       (mode),
        .stop_cmd   (stop_cmd),
        .istop_cmd  (istop_cmd),
        .list_clr   (list_clr),
        .list_wr    (list_wr),
        .list_wdata (list_wdata),
        .conv_ld    (conv_ld),
        .pre_ld     (pre_ld),
        .scan_ld    (scan_ld),
        .dly_ld     (dly_ld)
    );

    ai_scan_list #(.DEPTH(LIST_DEPTH)) u_list (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (list_clr),
        .wr     (list_wr),
        .wdata  (list_wdata),
        .rd_idx (rd_idx),
        .rdata  (entry),
        .count  (list_cnt)
    );

    ai_scan_fsm #(.TMR_W(TMR_W), .CH_W(CH_W), .IDX_W(IDX_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_rd  (start_rd),
        .ext_trig  (ext_trig),
        .mode      (mode),
        .stop_cmd  (stop_cmd),
        .istop_cmd (istop_cmd),
        .conv_ld   (conv_ld),
        .pre_ld    (pre_ld),
        .scan_ld   (scan_ld),
        .dly_ld    (dly_ld),
        .list_cnt  (list_cnt),
        .entry     (entry),
        .rd_idx    (rd_idx),
        .busy      (busy),
        .cvt_stb   (cvt_stb),
        .cvt_chan  (cvt_chan),
        .cvt_range (cvt_range),
        .cvt_diff  (cvt_diff),
        .cvt_last  (cvt_last)
    );

endmodule

// File: rtl/ai_scan_seq_chk.sv
module ai_scan_seq_chk
    import ai_scan_pkg::*;
#(
    parameter int TMR_W = 32,
    parameter int IDX_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [2:0]       wr_addr,
    input logic [TMR_W-1:0] wr_data,
    input logic             start_rd,
    input logic             busy,
    input logic             cvt_stb,
    input logic [IDX_W:0]   list_cnt
);

    logic wr_ctrl;
    assign wr_ctrl = wr_en && (wr_addr == A_CTRL);

    AST_ISTOP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && wr_data[CB_ISTOP]) |=> (!busy && !cvt_stb)); // R10

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && !wr_data[CB_LISTEN]) |=> (!busy && list_cnt == '0)); // R13

    AST_EMPTY_START: assert property (@(posedge clk) disable iff (!rst_n)
        (start_rd && !busy && list_cnt == '0) |=> !busy); // R13

    AST_LIST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !(wr_ctrl && !wr_data[CB_LISTEN])) |=> (list_cnt == $past(list_cnt))); // R12

    AST_STB_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        cvt_stb |-> $past(busy)); // R12

    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start_rd && !busy && list_cnt != '0 && !wr_ctrl) |=> busy); // R12

endmodule

bind ai_scan_seq ai_scan_seq_chk #(.TMR_W(TMR_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/sim_ai_scan_seq.sv
module sim_ai_scan_seq;

    localparam int CLK_PERIOD = 10;
    localparam int MAXS = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        start_rd = 1'b0;
    logic        ext_trig = 1'b0;
    logic        busy;
    logic        cvt_stb;
    logic [4:0]  cvt_chan;
    logic [1:0]  cvt_range;
    logic        cvt_diff;
    logic        cvt_last;

    ai_scan_seq u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .start_rd(start_rd), .ext_trig(ext_trig),
        .busy(busy), .cvt_stb(cvt_stb), .cvt_chan(cvt_chan),
        .cvt_range(cvt_range), .cvt_diff(cvt_diff), .cvt_last(cvt_last)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc = 0;
    int total = 0;
    int bad = 0;
    int n_stb = 0;
    int s_cyc  [MAXS];
    int s_chan [MAXS];
    int s_rng  [MAXS];
    int s_diff [MAXS];
    int s_last [MAXS];
    int last_edge;
    bit finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (cvt_stb) begin
            if (n_stb < MAXS) begin
                s_cyc[n_stb]  = cyc;
                s_chan[n_stb] = cvt_chan;
                s_rng[n_stb]  = cvt_range;
                s_diff[n_stb] = cvt_diff;
                s_last[n_stb] = cvt_last;
            end
            n_stb = n_stb + 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic host_wr(input logic [2:0] a, input logic [31:0] v);
        wr_en = 1'b1; wr_addr = a; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
        last_edge = cyc;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_start();
        start_rd = 1'b1;
        @(negedge clk);
        start_rd = 1'b0;
        last_edge = cyc;
    endtask

    task automatic pulse_trig();
        ext_trig = 1'b1;
        @(negedge clk);
        ext_trig = 1'b0;
        last_edge = cyc;
    endtask

    function automatic logic [31:0] ent(int ch, int df, int code, int lst);
        return 32'(ch) | (32'(df) << 5) | (32'(code) << 6) | (32'(lst) << 8);
    endfunction

    localparam logic [31:0] LISTEN = 32'h20;

    task automatic setup(int md, int dly, int pre, int conv, int scan);
        host_wr(3'd0, 32'h0);
        host_wr(3'd0, LISTEN | 32'(md));
        host_wr(3'd2, 32'(conv));
        host_wr(3'd3, 32'(pre));
        host_wr(3'd4, 32'(scan));
        host_wr(3'd5, 32'h0);
        host_wr(3'd6, 32'(dly));
        host_wr(3'd7, 32'h0);
        n_stb = 0;
    endtask

    task automatic halt_now(int md);
        host_wr(3'd0, LISTEN | 32'h10 | 32'(md));
    endtask

    task automatic t_reset();
        chk("R3 busy after reset", busy, 0);
        chk("R3 strobe after reset", cvt_stb, 0);
        chk("R3 no strobes", n_stb, 0);
    endtask

    task automatic t_timed_fields();
        int s, n0;
        setup(0, 4, 2, 3, 0);
        host_wr(3'd1, ent(3, 0, 0, 0));
        host_wr(3'd1, ent(17, 1, 2, 0));
        host_wr(3'd1, ent(9, 0, 3, 1));
        host_wr(3'd1, ent(30, 1, 1, 0));
        do_start(); s = last_edge;
        idle(40);
        halt_now(0);
        chk("R1 R4 first strobe edge", s_cyc[0] - s, 8);
        chk("R4 conversion gap", s_cyc[1] - s_cyc[0], 4);
        chk("R4 conversion gap 2", s_cyc[2] - s_cyc[1], 4);
        chk("R2 chan0", s_chan[0], 3);
        chk("R2 range0", s_rng[0], 3);
        chk("R2 diff0", s_diff[0], 0);
        chk("R2 chan1", s_chan[1], 17);
        chk("R2 range1", s_rng[1], 1);
        chk("R2 diff1", s_diff[1], 1);
        chk("R2 chan2", s_chan[2], 9);
        chk("R2 range2", s_rng[2], 0);
        chk("R2 last2", s_last[2], 1);
        chk("R2 last0", s_last[0], 0);
        chk("R5 wrap chan", s_chan[3], 3);
        chk("R5 wrap gap", s_cyc[3] - s_cyc[2], 3);
        n0 = n_stb;
        chk("R10 busy after halt", busy, 0);
        idle(20);
        chk("R10 no strobes after halt", n_stb, n0);
    endtask

    task automatic t_scan_timer();
        int s;
        setup(0, 1, 1, 2, 19);
        host_wr(3'd1, ent(5, 0, 0, 0));
        host_wr(3'd1, ent(6, 0, 0, 1));
        do_start(); s = last_edge;
        idle(50);
        halt_now(0);
        chk("R4 first strobe", s_cyc[0] - s, 4);
        chk("R4 gap", s_cyc[1] - s_cyc[0], 3);
        chk("R6 scan period", s_cyc[2] - s_cyc[0], 20);
        chk("R6 scan period 2", s_cyc[4] - s_cyc[2], 20);
        chk("R6 chan at scan start", s_chan[2], 5);
    endtask

    task automatic t_ext_start();
        int t;
        setup(1, 3, 2, 1, 0);
        host_wr(3'd1, ent(7, 0, 0, 0));
        host_wr(3'd1, ent(8, 0, 0, 1));
        do_start();
        idle(10);
        chk("R7 armed no strobe", n_stb, 0);
        chk("R12 busy while armed", busy, 1);
        pulse_trig(); t = last_edge;
        idle(30);
        halt_now(1);
        chk("R7 first strobe after trigger", s_cyc[0] - t, 7);
        chk("R7 chan", s_chan[0], 7);
    endtask

    task automatic t_ext_scan();
        int t0, t1, n0;
        setup(2, 2, 1, 2, 0);
        host_wr(3'd1, ent(1, 0, 0, 0));
        host_wr(3'd1, ent(2, 0, 0, 1));
        do_start();
        idle(3);
        pulse_trig(); t0 = last_edge;
        idle(20);
        n0 = n_stb;
        chk("R8 one scan without trigger", n0, 2);
        chk("R8 first strobe", s_cyc[0] - t0, 5);
        pulse_trig(); t1 = last_edge;
        idle(10);
        halt_now(2);
        chk("R8 scan trigger strobe", s_cyc[2] - t1, 2);
        chk("R8 scan trigger chan", s_chan[2], 1);
        chk("R8 scan count", n_stb, 4);
    endtask

    task automatic t_ext_conv();
        int t1, t2;
        setup(3, 2, 5, 5, 0);
        host_wr(3'd1, ent(10, 0, 0, 0));
        host_wr(3'd1, ent(11, 0, 0, 0));
        host_wr(3'd1, ent(12, 0, 0, 1));
        do_start();
        idle(2);
        pulse_trig();
        idle(1);
        pulse_trig();
        idle(6);
        chk("R9 edges during delay ignored", n_stb, 0);
        pulse_trig(); t1 = last_edge;
        idle(2);
        pulse_trig(); t2 = last_edge;
        idle(2);
        pulse_trig();
        idle(2);
        pulse_trig();
        idle(4);
        halt_now(3);
        chk("R9 strobe count", n_stb, 4);
        chk("R9 strobe at trigger edge", s_cyc[0], t1);
        chk("R9 strobe at trigger edge 2", s_cyc[1], t2);
        chk("R9 chan order", s_chan[1], 11);
        chk("R9 chan last", s_chan[2], 12);
        chk("R9 wrap", s_chan[3], 10);
    endtask

    task automatic t_stop_end();
        int s;
        setup(0, 1, 1, 1, 0);
        host_wr(3'd1, ent(20, 0, 0, 0));
        host_wr(3'd1, ent(21, 0, 0, 0));
        host_wr(3'd1, ent(22, 0, 0, 1));
        do_start(); s = last_edge;
        idle(4);
        host_wr(3'd0, LISTEN | 32'h08);
        idle(20);
        chk("R11 strobes finish scan", n_stb, 3);
        chk("R11 last chan", s_chan[2], 22);
        chk("R11 last edge", s_cyc[2] - s, 8);
        chk("R11 idle after scan", busy, 0);
    endtask

    task automatic t_frozen_list();
        setup(0, 1, 1, 1, 0);
        host_wr(3'd1, ent(4, 0, 0, 0));
        host_wr(3'd1, ent(5, 0, 0, 0));
        do_start();
        idle(3);
        chk("R12 busy when running", busy, 1);
        host_wr(3'd1, ent(6, 0, 0, 0));
        idle(20);
        halt_now(0);
        chk("R12 list write ignored", s_chan[2], 4);
        chk("R5 wrap at final stored entry", s_chan[1], 5);
    endtask

    task automatic t_clear();
        int n0;
        setup(0, 1, 1, 1, 0);
        host_wr(3'd1, ent(2, 0, 0, 1));
        do_start();
        idle(10);
        host_wr(3'd0, 32'h0);
        chk("R13 clear halts", busy, 0);
        n0 = n_stb;
        idle(10);
        chk("R13 no strobes after clear", n_stb, n0);
        host_wr(3'd0, LISTEN);
        do_start();
        idle(10);
        chk("R13 empty start ignored", busy, 0);
        chk("R13 empty start no strobe", n_stb, n0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_timed_fields();
        t_scan_timer();
        t_ext_start();
        t_ext_scan();
        t_ext_conv();
        t_stop_end();
        t_frozen_list();
        t_clear();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule